// File: doc/BRIEF.md
# Serial Flash Linear Read Sequencer with Line Buffer

This block answers 32-bit memory-mapped reads from a serial flash device through one line buffer. It holds a single line of `WORDS` 32-bit words (1 KiB by default) together with the bus address that filled it. A read that falls inside the line is answered from the buffer on the next cycle. A read outside the line triggers a refill. The refill drives one chip select low and sends a read-command header built from a configuration word. It then clocks `4*WORDS` zero bytes through a byte-level transfer port, packs the returned bytes into the buffer and answers the request.

The configuration word sets the command opcode, an optional mode byte and its enable, and the number of dummy bytes. A `dual_bus` input tells the block that two flash devices are striped. In that case the flash address is half the bus address. The upper flash-address bits choose which chip select is driven. The serialiser behind the byte port is outside this block.

Top module: `flash_line_reader`

## Requirements
- R1: After reset all `cs_n` lines are high, `rsp_valid`, `rsp_wait` and `xfer_req` are low, and the line buffer is invalid, so the first word read always causes a refill, even at address 0.
- R2: The configuration register resets to 0x03A002EB and is loaded from `cfg_wdata` when `cfg_wr` is high. Its fields are: opcode in bits 7:0, dummy-byte count in bits 10:8, mode byte in bits 23:16, and mode-byte enable in bit 25.
- R3: A refill sends its header in this order: the opcode, then flash address bits 23:16, 15:8 and 7:0, then the mode byte only if bit 25 is set, then as many 0x00 bytes as the dummy count. Bytes received during the header are discarded.
- R4: The flash address equals the bus address when `dual_bus` is 0, and the bus address shifted right by one when `dual_bus` is 1.
- R5: The chip-select index is the flash address shifted right by 24. That `cs_n` bit alone is low from the first header byte through the last data byte. All lines are high whenever `rsp_wait` is low.
- R6: After the header, a refill transfers exactly `4*WORDS` bytes, each sent as 0x00. Each group of four received bytes forms one word, with the first byte received in bits 7:0.
- R7: A word read is a hit when the line is valid and base <= address <= base + 4*WORDS - 4. A hit returns buffer word (address - base) >> 2 with `rsp_valid` in the cycle after acceptance and causes no byte transfer.
- R8: On a miss, `rsp_wait` is high from the cycle after acceptance until the refill ends. In the cycle it falls, `rsp_valid` delivers the requested word. The line base becomes the requesting address itself, even when that address is not line-aligned.
- R9: A request is accepted only while `rsp_wait` is low. A request presented during a refill is held off and then served from the new line.
- R10: A request whose `req_size` is not 2'b10 (32-bit) is ignored: no response, no transfer, and no change to the line.
- R11: `xfer_tx` stays stable while `xfer_req` is high and `xfer_ack` is low. A byte completes in a cycle where `xfer_req` and `xfer_ack` are both high, and `xfer_rx` carries the received byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 25+SEL_BITS | Byte address of the read |
| req_size | input | 2 | Access size, 2'b10 = 32-bit |
| rsp_wait | output | 1 | Refill in progress; requests are not accepted |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | 32 | Read data |
| cfg_wr | input | 1 | Load configuration word |
| cfg_wdata | input | 32 | New configuration word |
| dual_bus | input | 1 | Two striped devices: flash address = bus address / 2 |
| xfer_req | output | 1 | Byte transfer request |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte transfer done |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| cs_n | output | 2**SEL_BITS | Active-low chip selects |

## Verification
The bench builds the block with `SEL_BITS=1` and `WORDS=4`. The line is then only 16 bytes long, so a refill takes a few dozen cycles. This lets the bench sweep request offsets across both window edges around many unaligned bases. It does so for four configuration words (mode byte on and off, zero to seven dummy bytes, and an enable-bit decoy) in both single- and dual-bus modes, on both chip selects. A flash model answers header bytes with junk and data bytes with an arithmetic function of chip and address, so every returned word can be predicted by formula.

// File: rtl/flr_pkg.sv
package flr_pkg;
    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_FILL = 2'd2
    } flr_state_e;

    localparam logic [31:0] FLR_CFG_RESET   = 32'h03A0_02EB;
    localparam logic [1:0]  FLR_SIZE_WORD   = 2'b10;
    localparam int          FLR_MODE_EN_BIT = 25;
    localparam int          FLR_MODE_LSB    = 16;
    localparam int          FLR_DUMMY_LSB   = 8;
    localparam int          FLR_HDR_FIXED   = 4;
    localparam int          FLR_ADDR_BITS   = 24;
endpackage

// File: rtl/flr_hdr_gen.sv
// Header byte generator.
// Purpose: given the configuration word, the 24-bit flash address and a
// byte index, returns the header byte to send and the total header length.
// Assumes: the index stays below hdr_len; cfg is stable during a header.
module flr_hdr_gen
    import flr_pkg::*;
(
    input  logic [31:0] cfg,
    input  logic [23:0] flash_addr,
    input  logic [3:0]  idx,
    output logic [7:0]  tx_byte,
    output logic [3:0]  hdr_len
);
    logic       mode_en;
    logic [2:0] dummies;
    logic [7:0] mode_byte;
    logic [7:0] opcode;

    assign mode_en   = cfg[FLR_MODE_EN_BIT];
    assign dummies   = cfg[FLR_DUMMY_LSB +: 3];
    assign mode_byte = cfg[FLR_MODE_LSB +: 8];
    assign opcode    = cfg[7:0];
    assign hdr_len   = 4'(FLR_HDR_FIXED) + {3'b000, mode_en} + {1'b0, dummies};

    // Select the header byte for the current position
    always_comb begin
        unique case (idx)
            4'd0:    tx_byte = opcode;
            4'd1:    tx_byte = flash_addr[23:16];
            4'd2:    tx_byte = flash_addr[15:8];
            4'd3:    tx_byte = flash_addr[7:0];
            4'd4:    tx_byte = mode_en ? mode_byte : 8'h00;
            default: tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/flr_hit_check.sv
// Line window comparator.
// Purpose: decides whether an address falls in the buffered line and gives
// the word index inside it. The base may be any byte address.
// Assumes: WORDS is a power of two, at least 2.
module flr_hit_check #(
    parameter int BA_W  = 26,
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             line_valid,
    input  logic [BA_W-1:0]  base,
    input  logic [BA_W-1:0]  addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [BA_W:0] LAST_OFS = (BA_W+1)'(WORDS*4 - 4);

    logic [BA_W:0] upper;
    logic [BA_W:0] addr_x;
    logic [BA_W:0] base_x;

    assign base_x = {1'b0, base};
    assign addr_x = {1'b0, addr};
    assign upper  = base_x + LAST_OFS;

    // Window test and index extraction
    always_comb begin
        hit = line_valid && (addr_x >= base_x) && (addr_x <= upper);
        idx = IDX_W'((addr - base) >> 2);
    end
endmodule

// File: rtl/flr_line_store.sv
// Line buffer storage.
// Purpose: WORDS x 32 storage with one write port and a registered read port.
// Assumes: reads and writes never target the same word in one cycle.
module flr_line_store #(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem [WORDS];

    // Store refill words
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Registered read for hits
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/flash_line_reader.sv
// Serial flash linear read sequencer.
// Purpose: serves 32-bit reads from a single line buffer. On a miss it
// selects a chip, sends a read header, refills the whole line through a
// byte transfer port and answers with the requested word.
// Assumes: cfg and dual_bus are not changed while rsp_wait is high; the
// byte port completes each byte with a one-cycle xfer_ack.
module flash_line_reader
    import flr_pkg::*;
#(
    parameter int  SEL_BITS = 1,
    parameter int  WORDS    = 256,
    localparam int BA_W     = FLR_ADDR_BITS + SEL_BITS + 1,
    localparam int CS_N     = 1 << SEL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [BA_W-1:0] req_addr,
    input  logic [1:0]      req_size,
    output logic            rsp_wait,
    output logic            rsp_valid,
    output logic [31:0]     rsp_data,
    input  logic            cfg_wr,
    input  logic [31:0]     cfg_wdata,
    input  logic            dual_bus,
    output logic            xfer_req,
    output logic [7:0]      xfer_tx,
    input  logic            xfer_ack,
    input  logic [7:0]      xfer_rx,
    output logic [CS_N-1:0] cs_n
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int BC_W  = IDX_W + 2;
    localparam int CI_W  = BA_W - FLR_ADDR_BITS;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORDS*4 - 1);

    flr_state_e      state_q;
    logic [31:0]     cfg_q;
    logic            valid_q;
    logic [BA_W-1:0] base_q;
    logic [23:0]     fa_q;
    logic [3:0]      hidx_q;
    logic [BC_W-1:0] bcnt_q;
    logic [31:0]     asm_q;
    logic [31:0]     word0_q;
    logic            rsp_valid_q;
    logic            from_fill_q;
    logic [CS_N-1:0] cs_n_q;

    logic            acc;
    logic            hit;
    logic [IDX_W-1:0] hit_idx;
    logic [BA_W-1:0] fa_next;
    logic [CI_W-1:0] chip_idx;
    logic [CS_N-1:0] sel_vec;
    logic [7:0]      hdr_byte;
    logic [3:0]      hdr_len;
    logic [31:0]     asm_next;
    logic            word_done;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]     rd_word;

    assign acc      = req_valid && (state_q == ST_IDLE) && (req_size == FLR_SIZE_WORD);
    assign fa_next  = dual_bus ? (req_addr >> 1) : req_addr;
    assign chip_idx = CI_W'(fa_next >> FLR_ADDR_BITS);

    // One select per chip, driven when the index matches
    for (genvar gi = 0; gi < CS_N; gi++) begin : g_sel
        assign sel_vec[gi] = (chip_idx == CI_W'(gi));
    end

    flr_hit_check #(.BA_W(BA_W), .WORDS(WORDS)) u_hit (
        .line_valid (valid_q),
        .base       (base_q),
        .addr       (req_addr),
        .hit        (hit),
        .idx        (hit_idx)
    );

    flr_hdr_gen u_hdr (
        .cfg        (cfg_q),
        .flash_addr (fa_q),
        .idx        (hidx_q),
        .tx_byte    (hdr_byte),
        .hdr_len    (hdr_len)
    );

    assign asm_next  = {xfer_rx, asm_q[31:8]};
    assign word_done = (state_q == ST_FILL) && xfer_ack && (bcnt_q[1:0] == 2'b11);
    assign wr_idx    = bcnt_q[BC_W-1:2];

    flr_line_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_done),
        .wr_idx  (wr_idx),
        .wr_data (asm_next),
        .rd_en   (acc && hit),
        .rd_idx  (hit_idx),
        .rd_data (rd_word)
    );

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= FLR_CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_wdata;
    end

    // Lookup, header and refill sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            valid_q     <= 1'b0;
            base_q      <= '0;
            fa_q        <= '0;
            hidx_q      <= '0;
            bcnt_q      <= '0;
            asm_q       <= '0;
            word0_q     <= '0;
            rsp_valid_q <= 1'b0;
            from_fill_q <= 1'b0;
            cs_n_q      <= '1;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc && hit) begin
                        rsp_valid_q <= 1'b1;
                        from_fill_q <= 1'b0;
                    end else if (acc) begin
                        valid_q <= 1'b0;
                        base_q  <= req_addr;
                        fa_q    <= fa_next[23:0];
                        cs_n_q  <= ~sel_vec;
                        hidx_q  <= '0;
                        bcnt_q  <= '0;
                        asm_q   <= '0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (xfer_ack) begin
                        if (hidx_q == hdr_len - 4'd1) state_q <= ST_FILL;
                        else                          hidx_q  <= hidx_q + 4'd1;
                    end
                end
                ST_FILL: begin
                    if (xfer_ack) begin
                        asm_q  <= asm_next;
                        bcnt_q <= bcnt_q + 1'b1;
                        if (word_done && (wr_idx == '0)) word0_q <= asm_next;
                        if (bcnt_q == BC_LAST) begin
                            state_q     <= ST_IDLE;
                            cs_n_q      <= '1;
                            valid_q     <= 1'b1;
                            rsp_valid_q <= 1'b1;
                            from_fill_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_wait  = (state_q != ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = from_fill_q ? word0_q : rd_word;
    assign xfer_req  = (state_q == ST_HDR) || (state_q == ST_FILL);
    assign xfer_tx   = (state_q == ST_HDR) ? hdr_byte : 8'h00;
    assign cs_n      = cs_n_q;
endmodule

// File: rtl/flr_checker.sv
// Protocol checker for flash_line_reader, attached by bind.
// Purpose: watches port-level rules of the request and byte interfaces.
module flr_checker #(
    parameter int CS_N = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_size,
    input logic            rsp_wait,
    input logic            rsp_valid,
    input logic            xfer_req,
    input logic [7:0]      xfer_tx,
    input logic            xfer_ack,
    input logic [CS_N-1:0] cs_n
);
    // R5
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_wait |-> (&cs_n));

    // R7
    xfer_only_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_wait |-> !xfer_req);

    // R8
    rsp_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_wait);

    // R9
    rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && !rsp_wait && req_size == 2'b10) || $fell(rsp_wait)));

    // R10
    odd_size_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && req_size != 2'b10) |=> (!rsp_valid && !rsp_wait));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));
endmodule

bind flash_line_reader flr_checker #(.CS_N(CS_N)) u_flr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .rsp_wait  (rsp_wait),
    .rsp_valid (rsp_valid),
    .xfer_req  (xfer_req),
    .xfer_tx   (xfer_tx),
    .xfer_ack  (xfer_ack),
    .cs_n      (cs_n)
);

// File: tb/sim_flash_line_reader.sv
module sim_flash_line_reader;
    localparam int SEL_BITS = 1;
    localparam int WORDS    = 4;
    localparam int LB       = WORDS * 4;
    localparam int BA_W     = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [BA_W-1:0] req_addr = '0;
    logic [1:0]      req_size = 2'b10;
    logic            rsp_wait, rsp_valid;
    logic [31:0]     rsp_data;
    logic            cfg_wr = 1'b0;
    logic [31:0]     cfg_wdata = '0;
    logic            dual_bus = 1'b0;
    logic            xfer_req;
    logic [7:0]      xfer_tx;
    logic            xfer_ack = 1'b0;
    logic [7:0]      xfer_rx = '0;
    logic [1:0]      cs_n;

    int n_chk = 0;
    int n_bad = 0;
    int tot_bytes = 0;
    int sl_idx = 0;
    int data_tx_bad = 0;
    int exp_hlen = 7;
    logic [7:0] log_tx [0:31];
    logic [1:0] log_cs [0:31];

    logic [31:0] cfg_m = 32'h03A0_02EB;
    bit m_valid = 0;
    bit m_dual  = 0;
    int m_base = 0;
    int m_fa = 0;
    int m_chip = 0;

    always #4 clk = ~clk;

    flash_line_reader #(.SEL_BITS(SEL_BITS), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .rsp_wait(rsp_wait), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .dual_bus(dual_bus), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .cs_n(cs_n)
    );

    function automatic logic [7:0] fbyte(input int chip, input int a);
        return 8'(((a & 255) * 13) + (((a >> 8) & 255) * 5) + (((a >> 16) & 255) * 3) + chip * 90 + 1);
    endfunction

    function automatic logic [31:0] fword(input int chip, input int a);
        return {fbyte(chip, a + 3), fbyte(chip, a + 2), fbyte(chip, a + 1), fbyte(chip, a)};
    endfunction

    function automatic int hlen(input logic [31:0] c);
        return 4 + int'(c[25]) + int'(c[10:8]);
    endfunction

    function automatic logic [7:0] hbyte(input logic [31:0] c, input int fa, input int i);
        if (i == 0) return c[7:0];
        if (i == 1) return 8'(fa >> 16);
        if (i == 2) return 8'(fa >> 8);
        if (i == 3) return 8'(fa);
        if (i == 4 && c[25]) return c[23:16];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Flash model: acks every other cycle, junk during header, data after it
    initial begin
        forever begin
            @(negedge clk);
            if (&cs_n) sl_idx = 0;
            if (xfer_ack) xfer_ack = 1'b0;
            else if (xfer_req) begin
                int ch;
                ch = (cs_n == 2'b10) ? 0 : ((cs_n == 2'b01) ? 1 : 7);
                if (sl_idx < 32) begin
                    log_tx[sl_idx] = xfer_tx;
                    log_cs[sl_idx] = cs_n;
                end
                if (sl_idx < exp_hlen) xfer_rx = 8'hC3 ^ 8'(sl_idx);
                else begin
                    xfer_rx = fbyte(ch, m_fa + sl_idx - exp_hlen);
                    if (xfer_tx !== 8'h00) data_tx_bad++;
                end
                sl_idx++;
                tot_bytes++;
                xfer_ack = 1'b1;
            end
        end
    end

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_m = v;
    endtask

    // Wait for a refill result and check header, selects, data and count
    task automatic finish_miss(input int addr, input int fa, input int chip, input int b0);
        int n;
        int cs_bad;
        int hl;
        hl = hlen(cfg_m);
        chk("R8 wait high after miss", 32'(rsp_wait), 32'd1);
        n = 0;
        while (!rsp_valid && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 refill response", 32'(rsp_valid), 32'd1);
        chk(m_dual ? "R4 R6 R8 dual word" : "R6 R8 word", rsp_data, fword(chip, fa));
        chk("R6 byte count", 32'(tot_bytes - b0), 32'(hl + LB));
        chk("R6 data bytes sent as zero", 32'(data_tx_bad), 32'd0);
        for (int i = 0; i < hl; i++) chk("R2 R3 header byte", 32'(log_tx[i]), 32'(hbyte(cfg_m, fa, i)));
        cs_bad = 0;
        for (int i = 0; i < hl + LB; i++) if (log_cs[i] !== ~(2'(1) << chip)) cs_bad++;
        chk("R5 select during refill", 32'(cs_bad), 32'd0);
        chk("R5 selects released", 32'(cs_n), 32'h3);
        chk("R8 wait released", 32'(rsp_wait), 32'd0);
        m_valid = 1;
        m_base = addr;
        m_fa = fa;
        m_chip = chip;
    endtask

    task automatic do_read(input int addr);
        bit hit;
        int fa;
        int chip;
        int b0;
        logic [31:0] exp;
        hit = m_valid && addr >= m_base && addr <= m_base + LB - 4;
        fa = m_dual ? (addr >> 1) : addr;
        chip = fa >> 24;
        if (hit) exp = fword(m_chip, m_fa + ((addr - m_base) >> 2) * 4);
        else begin
            exp_hlen = hlen(cfg_m);
            m_fa = fa;
        end
        b0 = tot_bytes;
        data_tx_bad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = BA_W'(addr);
        req_size = 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk("R7 hit strobe", 32'(rsp_valid), 32'd1);
            chk("R7 hit data", rsp_data, exp);
            chk("R7 hit no transfer", 32'(tot_bytes - b0), 32'd0);
        end else finish_miss(addr, fa, chip, b0);
    endtask

    task automatic do_ignored(input int addr, input logic [1:0] sz);
        int b0;
        int stray;
        b0 = tot_bytes;
        stray = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = BA_W'(addr);
        req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        req_size = 2'b10;
        for (int i = 0; i < 4; i++) begin
            if (rsp_valid || rsp_wait) stray++;
            @(negedge clk);
        end
        chk("R10 no response to odd size", 32'(stray), 32'd0);
        chk("R10 no transfer for odd size", 32'(tot_bytes - b0), 32'd0);
    endtask

    initial begin
        logic [31:0] cfgs [4];
        cfgs[0] = 32'h03A0_02EB;
        cfgs[1] = 32'h0000_000B;
        cfgs[2] = 32'h02FF_076B;
        cfgs[3] = 32'h0155_03BB;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 selects high", 32'(cs_n), 32'h3);
        chk("R1 no response", 32'(rsp_valid), 32'd0);
        chk("R1 no wait", 32'(rsp_wait), 32'd0);
        chk("R1 no transfer", 32'(xfer_req), 32'd0);

        // R1 first read at address 0 misses; R2 reset config drives header
        do_read(0);
        for (int k = 1; k <= 4; k++) do_read(k * 4);

        // R3 R4 R5 R7 R8 sweeps over configs, bus modes and window edges
        for (int c = 0; c < 4; c++) begin
            cfg_write(cfgs[c]);
            for (int d = 0; d < 2; d++) begin
                int b;
                m_dual = bit'(d);
                dual_bus = 1'(d);
                b = 32'h104 + c * 32'h40 + d * 32'h800;
                do_read(b);
                for (int off = -8; off <= 20; off += 4) do_read(b + off);
                do_read((d != 0 ? 32'h200_0080 : 32'h100_0040) + c * 8);
                do_read((d != 0 ? 32'h200_0084 : 32'h100_0044) + c * 8);
            end
        end
        dual_bus = 1'b0;
        m_dual = 0;

        // R10 odd sizes at a hit and a miss address, then the line is intact
        do_ignored(m_base + 4, 2'b01);
        do_ignored(32'h30_0000, 2'b00);
        do_ignored(32'h30_0000, 2'b11);
        do_read(m_base + 8);

        // R9 request held during a refill is served afterwards from the new line
        begin
            int a1;
            int b0;
            int n;
            a1 = 32'h5_0100;
            exp_hlen = hlen(cfg_m);
            m_fa = a1;
            b0 = tot_bytes;
            data_tx_bad = 0;
            @(negedge clk);
            req_valid = 1'b1;
            req_addr = BA_W'(a1);
            @(negedge clk);
            req_addr = BA_W'(a1 + 8);
            chk("R9 wait during refill", 32'(rsp_wait), 32'd1);
            n = 0;
            while (!rsp_valid && n < 4000) begin
                @(negedge clk);
                n++;
            end
            chk("R9 first response", rsp_data, fword(0, a1));
            m_valid = 1;
            m_base = a1;
            m_fa = a1;
            m_chip = 0;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R9 held request answered", 32'(rsp_valid), 32'd1);
            chk("R9 held request data", rsp_data, fword(0, a1 + 8));
            chk("R9 single refill", 32'(tot_bytes - b0), 32'(hlen(cfg_m) + LB));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule